// File: doc/BRIEF.md
# Chainable Down-Counting Interval Timer

This block holds a set of down-counting timer channels behind a small register interface. Each channel has a reload register, a control word and an expiry flag. A running channel counts down by one each clock. When it reaches zero it reloads from its reload register and raises its flag. A channel other than the first can be placed in cascade mode. In that mode it steps only on the cycles in which the channel below it expires. The first two channels then act as one counter of twice the channel width.

Software reads that double-width counter through a snapshot pair. Reading the upper half captures the lower half in the same cycle, so a later read of the lower half returns a value that matches the upper half already read. A global halt bit freezes every channel and comes out of reset set. A single interrupt line reports any channel whose flag and interrupt enable are both set.

Register map (byte addresses, `addr[3:2]` selects the word):
- `0x00`: global control. Bit 0 is halt.
- `0x04`: snapshot upper half.
- `0x08`: snapshot lower half.
- Channel i uses the block starting at `(i+1)*0x10`. Its words are: `+0` reload, `+4` current count (read-only), `+8` control, `+C` flag.
- Control bits: bit 0 run, bit 1 interrupt enable, bit 2 cascade.
- Flag bit: bit 0, cleared by writing 1.

Top module: `chain_tmr`

## Requirements
- R1: After reset the halt bit (global control bit 0) reads 1, all reload, count, control and flag registers read 0, and `irq` is low.
- R2: A channel whose run bit is set, with halt clear and cascade clear, decrements its count by one on every clock while the count is non-zero.
- R3: A stepping channel whose count is zero reloads from its reload register and sets its flag (flag bit 0) on that clock, so its period is reload+1 steps.
- R4: Writing the reload register of a running channel does not change its current count. The new value is used first at the next expiry.
- R5: A control write that moves the run bit from 0 to 1 loads the count from the reload register on that clock. A control write with run already 1 does not reload.
- R6: A channel above channel 0 with cascade (control bit 2) set steps only on clocks in which the channel below it expires. The cascade bit of channel 0 has no effect on its counting.
- R7: A read of the snapshot upper word returns channel 1's count and captures channel 0's count. A later read of the snapshot lower word returns that captured value, even if channel 0 has moved on since.
- R8: Writing 1 to flag bit 0 clears the flag. Writing 0 leaves it unchanged.
- R9: `irq` is high exactly while some channel has both its flag and its interrupt enable (control bit 1) set.
- R10: While halt is 1 no channel count changes, except through the reload of R5. Clearing halt resumes counting from the held values.
- R11: With channels 0 and 1 both reloaded with all ones, channel 1 cascaded, and both started together, all ones of double width minus the snapshot equals the number of steps run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for the snapshot capture) |
| addr | input | ADDR_W | Byte address |
| wdata | input | W | Write data |
| rdata | output | W | Read data, combinational from `addr` |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with 8-bit channels and four channels. With that width the cascaded pair wraps its lower half after 256 steps, so a run of a few hundred clocks crosses the boundary between the two halves. Reload values from 0 up to 200 are each swept over run lengths of 1 to 12 steps. Expected counts and flags come from closed-form modular arithmetic on reload+1. Cascaded expiry counts and the double-width elapsed value are computed the same way.

// File: rtl/chain_tmr.sv
module chain_tmr #(
  parameter int W      = 32,
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic              irq
);
  localparam int SEG_W = ADDR_W - 4;

  logic [W-1:0]   load_q [NCH];
  logic [W-1:0]   cnt_q  [NCH];
  logic [NCH-1:0] run_q, ie_q, casc_q, flag_q;
  logic [NCH-1:0] step, expire, wr_ctrl;
  logic           halt_q;
  logic [W-1:0]   snap_q;

  wire [SEG_W-1:0] seg  = addr[ADDR_W-1:4];
  wire [1:0]       word = addr[3:2];
  wire             glb  = (seg == '0);

  logic unused_bits;
  assign unused_bits = ^{wdata[W-1:3], addr[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b1;
      snap_q <= '0;
    end else begin
      if (wr_en && glb && word == 2'd0) halt_q <= wdata[0];
      if (rd_en && glb && word == 2'd1) snap_q <= cnt_q[0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire hit     = (seg == SEG_W'(i + 1));
    wire wr_load = wr_en && hit && word == 2'd0;
    wire wr_flag = wr_en && hit && word == 2'd3;
    wire active  = run_q[i] && !halt_q;
    assign wr_ctrl[i] = wr_en && hit && word == 2'd2;

    if (i == 0) begin : g_first
      assign step[i] = active;
    end else begin : g_next
      assign step[i] = active && (!casc_q[i] || expire[i-1]);
    end
    assign expire[i] = step[i] && (cnt_q[i] == '0);

    wire start = wr_ctrl[i] && wdata[0] && !run_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        load_q[i] <= '0;
        cnt_q[i]  <= '0;
        run_q[i]  <= 1'b0;
        ie_q[i]   <= 1'b0;
        casc_q[i] <= 1'b0;
        flag_q[i] <= 1'b0;
      end else begin
        if (wr_load) load_q[i] <= wdata;
        if (wr_ctrl[i]) {casc_q[i], ie_q[i], run_q[i]} <= wdata[2:0];
        if (start)          cnt_q[i] <= load_q[i];
        else if (expire[i]) cnt_q[i] <= load_q[i];
        else if (step[i])   cnt_q[i] <= cnt_q[i] - 1'b1;
        if (expire[i])              flag_q[i] <= 1'b1;
        else if (wr_flag && wdata[0]) flag_q[i] <= 1'b0;
      end
    end

    p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !casc_q[i] && cnt_q[i] != '0 && !wr_ctrl[i]) |=> cnt_q[i] == $past(cnt_q[i]) - 1'b1);
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step[i] && cnt_q[i] == '0 && !wr_ctrl[i]) |=> (cnt_q[i] == $past(load_q[i]) && flag_q[i]));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !wr_ctrl[i]) |=> $stable(cnt_q[i]));
    p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && ie_q[i]) |-> irq);
    if (i > 0) begin : g_casc_chk
      p_casc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (casc_q[i] && !expire[i-1] && !wr_ctrl[i]) |=> $stable(cnt_q[i]));
    end
  end

  assign irq = |(flag_q & ie_q);

  always_comb begin
    rdata = '0;
    if (glb) begin
      case (word)
        2'd0:    rdata = W'(halt_q);
        2'd1:    rdata = cnt_q[1];
        2'd2:    rdata = snap_q;
        default: rdata = '0;
      endcase
    end
    for (int k = 0; k < NCH; k++) begin
      if (seg == SEG_W'(k + 1)) begin
        case (word)
          2'd0:    rdata = load_q[k];
          2'd1:    rdata = cnt_q[k];
          2'd2:    rdata = W'({casc_q[k], ie_q[k], run_q[k]});
          default: rdata = W'(flag_q[k]);
        endcase
      end
    end
  end

  p_reset_r1: assert property (@(posedge clk) $rose(rst_n) |-> (halt_q && !irq));
  p_snap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && glb && word == 2'd1) |=> snap_q == $past(cnt_q[0]));
endmodule

// File: tb/chain_tmr_bench.sv
`timescale 1ns/1ps
module chain_tmr_bench;
  localparam int W = 8;
  localparam int NCH = 4;
  localparam int ONES = 255;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  chain_tmr #(.W(W), .NCH(NCH), .ADDR_W(8)) u_chain_tmr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2.5 clk = ~clk;

  function automatic int ca(int ch, int off);
    return ((ch + 1) << 4) + off;
  endfunction
  function automatic int val1(int c, int l, int n);
    if (n <= c) return c - n;
    return l - ((n - c - 1) % (l + 1));
  endfunction
  function automatic int exps(int c, int l, int n);
    if (n <= c) return 0;
    return 1 + (n - c - 1) / (l + 1);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; addr = 8'(a); wdata = W'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); rd_en = 1; addr = 8'(a); #1 v = int'(rdata);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic run(int n);
    @(negedge clk); wr_en = 1; addr = 8'h00; wdata = '0;
    @(negedge clk);
    if (n > 1) begin wr_en = 0; repeat (n - 1) @(negedge clk); end
    wr_en = 1; addr = 8'h00; wdata = W'(1);
    @(negedge clk); wr_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, hi, lo;
    int loads[5] = '{0, 1, 3, 7, 200};
    int ml[4] = '{5, 2, 9, 0};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check("R1 irq", int'(irq), 0);
    rd(8'h00, v); check("R1 halt", v, 1);
    for (int c = 0; c < NCH; c++)
      for (int o = 0; o < 16; o += 4) begin
        rd(ca(c, o), v); check("R1 reg", v, 0);
      end

    // R5/R10: start under halt loads but holds
    wr(ca(0, 0), 9); wr(ca(0, 8), 1);
    repeat (4) @(negedge clk);
    rd(ca(0, 4), v); check("R5 R10 load on start, held", v, 9);

    // R2/R3 sweep
    foreach (loads[li]) begin
      for (int n = 1; n <= 12; n++) begin
        wr(ca(0, 8), 0); wr(ca(0, 0), loads[li]); wr(ca(0, 8), 1);
        run(n);
        rd(ca(0, 4), v); check("R2 R3 count", v, val1(loads[li], loads[li], n));
        rd(ca(0, 12), v); check("R3 flag", v, (n > loads[li]) ? 1 : 0);
        wr(ca(0, 12), 1);
      end
    end
    rd(ca(0, 12), v); check("R8 flag cleared by 1", v, 0);

    // R8: writing 0 keeps flag
    wr(ca(0, 8), 0); wr(ca(0, 0), 0); wr(ca(0, 8), 1); run(1);
    wr(ca(0, 12), 0);
    rd(ca(0, 12), v); check("R8 write 0 keeps flag", v, 1);
    wr(ca(0, 12), 1);

    // R2/R3 all channels together
    for (int n = 3; n <= 15; n += 4) begin
      for (int c = 0; c < NCH; c++) begin
        wr(ca(c, 8), 0); wr(ca(c, 0), ml[c]); wr(ca(c, 8), 1);
      end
      run(n);
      for (int c = 0; c < NCH; c++) begin
        rd(ca(c, 4), v); check("R2 R3 multi count", v, val1(ml[c], ml[c], n));
        rd(ca(c, 12), v); check("R3 multi flag", v, (n > ml[c]) ? 1 : 0);
        wr(ca(c, 12), 1);
      end
    end
    for (int c = 0; c < NCH; c++) wr(ca(c, 8), 0);

    // R4 and R5 restart
    wr(ca(0, 0), 10); wr(ca(0, 8), 1); run(3);
    rd(ca(0, 4), v); check("R2 before reload change", v, 7);
    wr(ca(0, 0), 4);
    rd(ca(0, 4), v); check("R4 count kept", v, 7);
    wr(ca(0, 8), 1);
    rd(ca(0, 4), v); check("R5 no reload when already running", v, 7);
    run(8);
    rd(ca(0, 4), v); check("R4 new reload at expiry", v, val1(7, 4, 8));
    run(2);
    wr(ca(0, 8), 0); wr(ca(0, 8), 1);
    rd(ca(0, 4), v); check("R5 restart", v, 4);
    wr(ca(0, 8), 0); wr(ca(0, 12), 1);

    // R6 cascade, channel 0 cascade bit ignored
    wr(ca(0, 0), 3); wr(ca(1, 0), 5);
    wr(ca(1, 8), 5); wr(ca(0, 8), 5);
    run(11);
    rd(ca(0, 4), v); check("R6 ch0 ignores cascade", v, val1(3, 3, 11));
    rd(ca(1, 4), v); check("R6 cascaded count", v, val1(5, 5, exps(3, 3, 11)));
    run(13);
    rd(ca(1, 4), v); check("R6 cascaded count 2", v, val1(5, 5, exps(3, 3, 24)));
    wr(ca(0, 8), 0); wr(ca(1, 8), 0);
    wr(ca(0, 12), 1); wr(ca(1, 12), 1);

    // R9 irq
    wr(ca(2, 0), 0); wr(ca(2, 8), 3); run(1);
    #1 check("R9 irq on", int'(irq), 1);
    wr(ca(2, 8), 1); #1 check("R9 irq masked", int'(irq), 0);
    wr(ca(2, 8), 3); #1 check("R9 irq again", int'(irq), 1);
    wr(ca(2, 12), 1); #1 check("R9 irq after clear", int'(irq), 0);
    wr(ca(2, 8), 0);

    // R11 / R7 double-width counter and snapshot
    wr(ca(0, 0), ONES); wr(ca(1, 0), ONES);
    wr(ca(1, 8), 5); wr(ca(0, 8), 1);
    run(300);
    rd(8'h04, hi); rd(8'h08, lo);
    check("R11 elapsed", 65535 - ((hi << 8) | lo), 300);
    rd(8'h04, hi);
    run(5);
    rd(8'h08, lo);
    check("R7 snapshot held", lo, (65535 - 300) & 255);
    check("R7 upper half", hi, (65535 - 300) >> 8);
    rd(8'h04, hi); rd(8'h08, lo);
    check("R7 R11 fresh snapshot", (hi << 8) | lo, 65535 - 305);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule